// File: doc/BRIEF.md
# Z80 Bus Glue: Port Decoder with Paged RAM/ROM Mapping

This block is the address glue for an 8-bit Z80-style processor bus. In an I/O cycle it looks at the low byte of the address. A hit in the 32-port on-board window at 60h..7Fh raises one peripheral select, or reaches one of two page registers. Any other port is handed to the expansion bus through an enable.

In a memory cycle it splits the 64 KB CPU space into a switchable region and a fixed region. It reports which memory chip is selected and the upper physical address bits for that chip. The low 15 address bits pass straight from the CPU to both memories.

A strap input chooses between two maps. In one, 32K is switchable and 32K is fixed. In the other, 48K is switchable and 16K is fixed. The switchable region shows a ROM page, or a RAM page when the ROM is turned off in its register. The fixed region always shows the highest RAM page.

The page registers are loaded once per write strobe. They can be read back on the data bus. All bus control inputs are active-low and the selects are active-high. The block has no streaming interface, so no pin uses a valid/ready handshake.

Top module: `z80_glue_dec`

## Requirements
- R1: A port cycle is recognised only while `iorq_n` is low and `m1_n` is high. With `m1_n` low (interrupt acknowledge), no peripheral select and no `ext_io_en` is raised.
- R2: `ppi_cs` is high in a port cycle to any port 60h..67h, so 64h..67h mirror 60h..63h.
- R3: `uart_cs` is high in a port cycle to any port 68h..6Fh.
- R4: `rtc_cs` is high in a port cycle to port 70h or 71h.
- R5: `ext_io_en` is high in a port cycle to any port below 60h or above 7Fh, and no on-board select is then high. Ports 72h..77h, 7Ah, 7Bh, 7Dh and 7Fh raise no select and no `ext_io_en`.
- R6: A port write to 78h or 79h loads the 4-bit RAM page from `d_in[3:0]`. The load happens once per strobe, on its first clock, so a data change while the strobe is held is ignored. A port read of 78h/79h returns {0000, page}.
- R7: A port write to 7Ch or 7Eh loads the ROM register: bit 7 is the ROM disable and bits 4:0 are the ROM page. Writes to 7Dh and 7Fh change nothing. A port read of 7Ch/7Eh returns {disable, 00, page}.
- R8: After reset both registers are zero: ROM is enabled at page 0 and the RAM page is 0.
- R9: With `map_strap` low, addresses 8000h..FFFFh select RAM with `ram_hi` = 15. Addresses 0000h..7FFFh select ROM at page `rom_hi` = ROM page. When the ROM is disabled, they select RAM at `ram_hi` = RAM page instead.
- R10: With `map_strap` high, C000h..FFFFh are fixed at RAM page 15. In 0000h..BFFFh the bank is the register page plus address bit 15, wrapping modulo the page count.
- R11: `ram_cs`/`rom_cs` are high only while `mreq_n` is low and `rd_n` or `wr_n` is low. At most one of all six selects is high at a time.
- R12: `d_oe` is high only during a port read (`iorq_n`, `rd_n` low, `m1_n` high) of a page register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 16 | CPU address |
| d_in | input | 8 | Data from CPU |
| d_out | output | 8 | Page register readback |
| d_oe | output | 1 | Drive enable for `d_out` |
| map_strap | input | 1 | 0: 32K/32K map, 1: 48K/16K map |
| ppi_cs | output | 1 | Parallel peripheral select |
| uart_cs | output | 1 | UART select |
| rtc_cs | output | 1 | RTC latch select |
| ram_cs | output | 1 | SRAM select |
| rom_cs | output | 1 | ROM select |
| ram_hi | output | 4 | SRAM address bits 18:15 |
| rom_hi | output | 5 | ROM address bits 19:15 |
| ext_io_en | output | 1 | Expansion bus I/O enable |

## Verification
The bench builds the block with its default widths: a 4-bit RAM page and a 5-bit ROM page. With these widths the fixed bank is page 15. They also make the 48K map's bank increment wrap, from ROM page 31 to 0 and from RAM page 15 to 0, which the bench drives directly. Keeping the window base at 60h lets the bench probe both edges of the on-board window (5Fh, 60h, 7Fh, 80h) and every alias port.

// File: rtl/z80gl_pkg.sv
package z80gl_pkg;
  typedef struct packed {
    logic ppi;
    logic uart;
    logic rtc;
    logic ram_reg;
    logic rom_reg;
    logic ext;
  } io_sel_t;
endpackage

// File: rtl/z80gl_io_dec.sv
module z80gl_io_dec
  import z80gl_pkg::*;
#(
  parameter logic [7:0] WIN_BASE = 8'h60
) (
  input  logic       iorq_n,
  input  logic       m1_n,
  input  logic [7:0] port,
  output io_sel_t    sel
);
  localparam int OFF_W = 5;
  logic             io_cyc;
  logic             in_win;
  logic [OFF_W-1:0] off;

  assign io_cyc = !iorq_n && m1_n;
  assign in_win = (port[7:OFF_W] == WIN_BASE[7:OFF_W]);
  assign off    = port[OFF_W-1:0];

  always_comb begin
    sel = '0;
    if (io_cyc) begin
      if (!in_win) begin
        sel.ext = 1'b1;
      end else begin
        sel.ppi     = (off[4:3] == 2'b00);
        sel.uart    = (off[4:3] == 2'b01);
        sel.rtc     = (off[4:1] == 4'b1000);
        sel.ram_reg = (off[4:1] == 4'b1100);
        sel.rom_reg = (off[4:2] == 3'b111) && !off[0];
      end
    end
  end
endmodule

// File: rtl/z80gl_page_regs.sv
module z80gl_page_regs
  import z80gl_pkg::*;
#(
  parameter int RAM_PAGE_W = 4,
  parameter int ROM_PAGE_W = 5,
  parameter int DIS_BIT    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  io_sel_t               sel,
  input  logic [7:0]            d_in,
  output logic [RAM_PAGE_W-1:0] ram_pg,
  output logic [ROM_PAGE_W-1:0] rom_pg,
  output logic                  rom_dis,
  output logic [7:0]            d_out,
  output logic                  d_oe
);
  logic reg_hit;
  logic stb;
  logic stb_q;
  logic stb_rise;

  assign reg_hit  = sel.ram_reg || sel.rom_reg;
  assign stb      = reg_hit && !wr_n;
  assign stb_rise = stb && !stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      ram_pg  <= '0;
      rom_pg  <= '0;
      rom_dis <= 1'b0;
    end else begin
      stb_q <= stb;
      if (stb_rise && sel.ram_reg) begin
        ram_pg <= d_in[RAM_PAGE_W-1:0];
      end
      if (stb_rise && sel.rom_reg) begin
        rom_pg  <= d_in[ROM_PAGE_W-1:0];
        rom_dis <= d_in[DIS_BIT];
      end
    end
  end

  always_comb begin
    d_out = '0;
    if (sel.ram_reg) begin
      d_out[RAM_PAGE_W-1:0] = ram_pg;
    end else if (sel.rom_reg) begin
      d_out[ROM_PAGE_W-1:0] = rom_pg;
      d_out[DIS_BIT]        = rom_dis;
    end
  end

  assign d_oe = reg_hit && !rd_n;
endmodule

// File: rtl/z80gl_mem_map.sv
module z80gl_mem_map #(
  parameter int RAM_PAGE_W = 4,
  parameter int ROM_PAGE_W = 5
) (
  input  logic                  mreq_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic [15:0]           addr,
  input  logic                  map_strap,
  input  logic [RAM_PAGE_W-1:0] ram_pg,
  input  logic [ROM_PAGE_W-1:0] rom_pg,
  input  logic                  rom_dis,
  output logic                  ram_cs,
  output logic                  rom_cs,
  output logic [RAM_PAGE_W-1:0] ram_hi,
  output logic [ROM_PAGE_W-1:0] rom_hi
);
  localparam logic [RAM_PAGE_W-1:0] TOP_PAGE = '1;
  logic active;
  logic fixed;
  logic bump;

  assign active = !mreq_n && (!rd_n || !wr_n);
  assign fixed  = map_strap ? (addr[15:14] == 2'b11) : addr[15];
  assign bump   = map_strap && addr[15];

  always_comb begin
    rom_hi = rom_pg + ROM_PAGE_W'(bump);
    if (fixed) ram_hi = TOP_PAGE;
    else       ram_hi = ram_pg + RAM_PAGE_W'(bump);
    ram_cs = active && (fixed || rom_dis);
    rom_cs = active && !fixed && !rom_dis;
  end
endmodule

// File: rtl/z80_glue_dec.sv
module z80_glue_dec
  import z80gl_pkg::*;
#(
  parameter int         RAM_PAGE_W = 4,
  parameter int         ROM_PAGE_W = 5,
  parameter logic [7:0] WIN_BASE   = 8'h60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mreq_n,
  input  logic                  iorq_n,
  input  logic                  m1_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic [15:0]           addr,
  input  logic [7:0]            d_in,
  output logic [7:0]            d_out,
  output logic                  d_oe,
  input  logic                  map_strap,
  output logic                  ppi_cs,
  output logic                  uart_cs,
  output logic                  rtc_cs,
  output logic                  ram_cs,
  output logic                  rom_cs,
  output logic [RAM_PAGE_W-1:0] ram_hi,
  output logic [ROM_PAGE_W-1:0] rom_hi,
  output logic                  ext_io_en
);
  io_sel_t               sel;
  logic [RAM_PAGE_W-1:0] ram_pg;
  logic [ROM_PAGE_W-1:0] rom_pg;
  logic                  rom_dis;

  z80gl_io_dec #(.WIN_BASE(WIN_BASE)) u_io (
    .iorq_n(iorq_n), .m1_n(m1_n), .port(addr[7:0]), .sel(sel)
  );

  z80gl_page_regs #(.RAM_PAGE_W(RAM_PAGE_W), .ROM_PAGE_W(ROM_PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
    .d_in(d_in), .ram_pg(ram_pg), .rom_pg(rom_pg), .rom_dis(rom_dis),
    .d_out(d_out), .d_oe(d_oe)
  );

  z80gl_mem_map #(.RAM_PAGE_W(RAM_PAGE_W), .ROM_PAGE_W(ROM_PAGE_W)) u_map (
    .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .map_strap(map_strap), .ram_pg(ram_pg), .rom_pg(rom_pg),
    .rom_dis(rom_dis), .ram_cs(ram_cs), .rom_cs(rom_cs),
    .ram_hi(ram_hi), .rom_hi(rom_hi)
  );

  assign ppi_cs    = sel.ppi;
  assign uart_cs   = sel.uart;
  assign rtc_cs    = sel.rtc;
  assign ext_io_en = sel.ext;
endmodule

// File: rtl/z80_glue_chk.sv
module z80_glue_chk #(
  parameter int RAM_PAGE_W = 4,
  parameter int ROM_PAGE_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mreq_n,
  input logic                  iorq_n,
  input logic                  m1_n,
  input logic                  rd_n,
  input logic                  wr_n,
  input logic [15:0]           addr,
  input logic                  map_strap,
  input logic                  d_oe,
  input logic                  ppi_cs,
  input logic                  uart_cs,
  input logic                  rtc_cs,
  input logic                  ram_cs,
  input logic                  rom_cs,
  input logic [RAM_PAGE_W-1:0] ram_hi,
  input logic                  ext_io_en,
  input logic [RAM_PAGE_W-1:0] ram_pg,
  input logic [ROM_PAGE_W-1:0] rom_pg,
  input logic                  rom_dis
);
  assert_m1_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_n |-> !(ppi_cs || uart_cs || rtc_cs || ext_io_en));

  assert_ext_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_io_en |-> !(ppi_cs || uart_cs || rtc_cs || d_oe));

  assert_ram_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iorq_n |=> $stable(ram_pg));

  assert_rom_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iorq_n |=> ($stable(rom_pg) && $stable(rom_dis)));

  assert_fixed_32k_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_strap && !mreq_n && !rd_n && addr[15]) |-> (ram_cs && ram_hi == '1));

  assert_fixed_16k_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (map_strap && !mreq_n && !rd_n && addr[15:14] == 2'b11) |-> (ram_cs && ram_hi == '1));

  assert_one_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ppi_cs, uart_cs, rtc_cs, ram_cs, rom_cs, ext_io_en}));

  assert_mem_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cs || rom_cs) |-> (!mreq_n && (!rd_n || !wr_n)));

  assert_doe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (!iorq_n && !rd_n && m1_n));
endmodule

bind z80_glue_dec z80_glue_chk #(.RAM_PAGE_W(RAM_PAGE_W), .ROM_PAGE_W(ROM_PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n),
  .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .map_strap(map_strap), .d_oe(d_oe),
  .ppi_cs(ppi_cs), .uart_cs(uart_cs), .rtc_cs(rtc_cs), .ram_cs(ram_cs),
  .rom_cs(rom_cs), .ram_hi(ram_hi), .ext_io_en(ext_io_en),
  .ram_pg(ram_pg), .rom_pg(rom_pg), .rom_dis(rom_dis)
);

// File: tb/z80_glue_dec_tb.sv
module z80_glue_dec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  d_in = '0;
  logic        map_strap = 1'b0;
  logic [7:0]  d_out;
  logic        d_oe, ppi_cs, uart_cs, rtc_cs, ram_cs, rom_cs, ext_io_en;
  logic [3:0]  ram_hi;
  logic [4:0]  rom_hi;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [3:0] m_ram = '0;
  logic [4:0] m_rom = '0;
  logic       m_dis = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  z80_glue_dec u_dut (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .d_in(d_in), .d_out(d_out),
    .d_oe(d_oe), .map_strap(map_strap), .ppi_cs(ppi_cs), .uart_cs(uart_cs),
    .rtc_cs(rtc_cs), .ram_cs(ram_cs), .rom_cs(rom_cs), .ram_hi(ram_hi),
    .rom_hi(rom_hi), .ext_io_en(ext_io_en)
  );

  // Expected outputs from the requirement text, packed as
  // {ppi,uart,rtc,ram_cs,rom_cs,ext, ram_hi, rom_hi, d_oe, d_out}
  function automatic logic [23:0] model();
    logic io, win, fixed, bump, act, pr, rr;
    logic [7:0] p;
    logic [3:0] rh;
    logic [4:0] oh;
    logic [7:0] dq;
    p     = addr[7:0];
    io    = !iorq_n && m1_n;
    win   = (p >= 8'h60) && (p <= 8'h7F);
    pr    = io && (p == 8'h78 || p == 8'h79);
    rr    = io && (p == 8'h7C || p == 8'h7E);
    fixed = map_strap ? (addr >= 16'hC000) : (addr >= 16'h8000);
    bump  = map_strap && addr[15];
    act   = !mreq_n && (!rd_n || !wr_n);
    rh    = fixed ? 4'd15 : m_ram + {3'b0, bump};
    oh    = m_rom + {4'b0, bump};
    dq    = pr ? {4'b0, m_ram} : (rr ? {m_dis, 2'b0, m_rom} : 8'h00);
    return {io && p >= 8'h60 && p <= 8'h67,
            io && p >= 8'h68 && p <= 8'h6F,
            io && (p == 8'h70 || p == 8'h71),
            act && (fixed || m_dis),
            act && !fixed && !m_dis,
            io && !win,
            rh, oh, (pr || rr) && !rd_n, dq};
  endfunction

  // Driver: one bus state per cycle, optionally queued for checking
  task automatic step(input logic mq, iq, m1, rd, wr, input logic [15:0] a,
                      input logic [7:0] d, input logic chk, input string tag);
    @(posedge clk);
    #2;
    mreq_n = mq; iorq_n = iq; m1_n = m1; rd_n = rd; wr_n = wr; addr = a; d_in = d;
    if (chk) begin
      exp_q.push_back(model());
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle();
    step(1, 1, 1, 1, 1, 16'h0000, 8'h00, 0, "");
  endtask

  task automatic io_rd(input logic [7:0] p, input string tag);
    step(1, 0, 1, 0, 1, {8'h00, p}, 8'h00, 1, tag);
  endtask

  task automatic mem_rd(input logic [15:0] a, input string tag);
    step(0, 1, 1, 0, 1, a, 8'h00, 1, tag);
  endtask

  // Write strobe held two cycles; data changes in the second cycle
  task automatic io_wr(input logic [7:0] p, input logic [7:0] d1,
                       input logic [7:0] d2, input string tag);
    step(1, 0, 1, 1, 0, {8'h00, p}, d1, 1, tag);
    step(1, 0, 1, 1, 0, {8'h00, p}, d2, 0, tag);
    idle();
    if (p == 8'h78 || p == 8'h79) m_ram = d1[3:0];
    if (p == 8'h7C || p == 8'h7E) begin m_rom = d1[4:0]; m_dis = d1[7]; end
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [23:0] e, g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {ppi_cs, uart_cs, rtc_cs, ram_cs, rom_cs, ext_io_en, ram_hi, rom_hi, d_oe, d_out};
      checks++;
      if (g !== e) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, addr, g, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle();
    // R8: reset state
    mem_rd(16'h0000, "R8 boot from ROM page 0");
    io_rd(8'h78, "R8 RAM page reads zero");
    io_rd(8'h7C, "R8 ROM reg reads zero");
    // R2..R5 port decode
    io_rd(8'h60, "R2 ppi base");
    io_rd(8'h65, "R2 ppi mirror");
    io_rd(8'h68, "R3 uart low");
    io_rd(8'h6F, "R3 uart high");
    io_rd(8'h70, "R4 rtc");
    io_rd(8'h71, "R4 rtc alias");
    io_rd(8'h72, "R5 unused in window");
    io_rd(8'h7D, "R5 unused 7D");
    io_rd(8'h7F, "R5 unused 7F");
    io_rd(8'h5F, "R5 ext below window");
    io_rd(8'h80, "R5 ext above window");
    io_rd(8'hFF, "R5 ext top");
    // R1: acknowledge cycle
    step(1, 0, 0, 1, 1, 16'h0060, 8'h00, 1, "R1 m1 low at 60h");
    step(1, 0, 0, 1, 1, 16'h0010, 8'h00, 1, "R1 m1 low at 10h");
    idle();
    // R6: RAM page register
    io_wr(8'h78, 8'hF5, 8'h0A, "R6 write 78h");
    io_rd(8'h79, "R6 readback alias 79h");
    mem_rd(16'h1234, "R9 ROM still enabled");
    io_wr(8'h79, 8'h0C, 8'h03, "R6 write alias 79h");
    io_rd(8'h78, "R6 readback single capture");
    io_wr(8'h78, 8'h05, 8'h05, "R6 restore");
    // R7: ROM register
    io_wr(8'h7C, 8'h83, 8'h11, "R7 write 7Ch");
    io_rd(8'h7E, "R7 readback alias 7Eh");
    mem_rd(16'h1234, "R9 ROM disabled maps RAM page");
    mem_rd(16'h9000, "R9 fixed upper RAM");
    io_wr(8'h7D, 8'h00, 8'h00, "R7 write 7Dh");
    m_rom = 5'd3; m_dis = 1'b1;   // 7Dh must not change the register
    io_rd(8'h7C, "R7 7Dh ignored");
    io_wr(8'h7F, 8'h00, 8'h00, "R7 write 7Fh");
    m_rom = 5'd3; m_dis = 1'b1;
    io_rd(8'h7C, "R7 7Fh ignored");
    io_wr(8'h7E, 8'h1F, 8'h00, "R7 enable page 31");
    mem_rd(16'h0000, "R9 ROM page 31");
    mem_rd(16'h7FFF, "R9 top of switchable");
    mem_rd(16'h8000, "R9 bottom of fixed");
    // R10: 48K/16K map
    step(1, 1, 1, 1, 1, 16'h0000, 8'h00, 0, "");
    map_strap = 1'b1;
    mem_rd(16'h4000, "R10 ROM page 31 low");
    mem_rd(16'h8000, "R10 ROM page wraps to 0");
    mem_rd(16'hBFFF, "R10 top of switchable");
    mem_rd(16'hC000, "R10 fixed 16K");
    io_wr(8'h7C, 8'h80, 8'h00, "R10 disable ROM");
    io_wr(8'h78, 8'h0F, 8'h00, "R10 RAM page 15");
    mem_rd(16'h0100, "R10 RAM page 15 low");
    mem_rd(16'h8100, "R10 RAM page wraps to 0");
    mem_rd(16'hFFFF, "R10 fixed top");
    // R11: no memory select without a strobe; R12: no drive on write
    step(0, 1, 1, 1, 1, 16'h4000, 8'h00, 1, "R11 mreq without strobe");
    step(0, 1, 1, 1, 0, 16'h4000, 8'h00, 1, "R11 memory write");
    step(1, 1, 1, 0, 1, 16'h0078, 8'h00, 1, "R12 read without iorq");
    step(1, 0, 0, 0, 1, 16'h0078, 8'h00, 1, "R12 read during acknowledge");
    idle();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule